// File: doc/BRIEF.md
# Byte-Addressed Status and Setup Target on a Two-Wire Bus

This block lets a host controller reach a 256-location byte map over a two-wire serial bus. The host selects the target with a 7-bit address, picks a location by sending a pointer byte, and then streams data bytes in or out. Each byte moves the pointer on by one. A few locations are served inside the block: a fixed identity byte, a general status byte with a self-clearing reset flag, the slider position, and a reset command location. All other reads come from a register-file port toward the sensing core, and writes at or above a configurable base go out on that same port.

An active-low attention line tells the host that the status byte or the slider byte holds a value it has not yet read. Writing a nonzero value to the reset command location makes the target go quiet. It then waits a programmable number of clocks and returns every piece of its state to the power-up values. The block is clocked from the system clock and oversamples both bus lines. It only ever pulls SDA low and never holds SCL.

Top module: `i2c_regmap_target`

## Requirements
- R1: The target answers to the 7-bit address ADDR_BASE + strap (default base 0x44, strap 0..3) by pulling SDA low on the ninth clock of the address byte; on any other address it leaves SDA released and ignores the bus until the next START.
- R2: Bytes are carried MSB first, and the target changes its SDA drive only while SCL is low.
- R3: In a write, the first byte after the address loads the pointer; each following byte is acknowledged and written at the pointer, which then increments.
- R4: In a read (address byte LSB = 1), the first byte comes from the current pointer, the pointer increments after each byte, a host NACK makes the target release SDA, and STOP returns it to idle.
- R5: The pointer saturates at 255: further reads return location 255 again, and further writes overwrite location 255.
- R6: Location 0 reads as the identity value 0x11.
- R7: Location 2 reads as {resetFlag, coreFlags[6:0]}, where bit 6 is the cycle-overrun input. The reset flag is 1 after any reset and clears once the host has read location 2.
- R8: changeN is low whenever location 2 or location 5 (slider position) differs from the value the host last read there. Reading those locations returns changeN high. After a reset, changeN is low.
- R9: Writes to locations 0..10 are acknowledged but change nothing and do not assert regWrEn. Writes to locations 12 and above appear on regWrEn/regAddr/regWrData. Reads of locations other than 0, 2, 5 and 11 return regRdData for regAddr, and location 11 reads 0.
- R10: A nonzero write to location 11 at once makes the target refuse its address and hold changeN high. After RST_CLKS clocks it pulses softRst for one cycle and restores the reset state (pointer 0, reset flag set, changeN low). Writing 0 there has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| scl | input | 1 | Bus clock line level |
| sda | input | 1 | Bus data line level |
| sdaLow | output | 1 | Pull SDA low when 1 (open-drain enable) |
| strap | input | 2 | Address strap, added to ADDR_BASE |
| coreFlags | input | 7 | Status bits 6..0 of location 2 (bit 6 cycle overrun) |
| sliderPos | input | 8 | Slider position served at location 5 |
| regAddr | output | 8 | Current pointer, address of the register-file port |
| regWrEn | output | 1 | One-cycle write strobe for locations at or above 12 |
| regWrData | output | 8 | Write data for the register-file port |
| regRdData | input | 8 | Read data from the register-file port for regAddr |
| softRst | output | 1 | One-cycle pulse when a commanded reset completes |
| changeN | output | 1 | Active-low attention line |

## Verification
A wrong pointer shows up within one byte as the wrong data on the bus or as a write at the wrong regAddr. Faults in saturation only appear on the second byte past location 254. A stale snapshot of the status or slider bytes leaves changeN stuck in the wrong state right after the host reads those bytes. A lost reset flag shows on the first read of location 2. A fault in the reset sequence shows as an acknowledge where there should be none during the quiet window, or as a missing softRst pulse after RST_CLKS clocks.

// File: rtl/i2c_regmap_pkg.sv
package i2c_regmap_pkg;
  typedef struct packed {
    logic       ptrLoad;
    logic       wrStrobe;
    logic       rdFetch;
    logic [7:0] data;
  } regStrobe_t;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_PTR, S_PTR_ACK,
    S_WDAT, S_WDAT_ACK, S_RDAT, S_RACK
  } busState_t;
endpackage

// File: rtl/i2c_regmap_ctl.sv
module i2c_regmap_ctl
  import i2c_regmap_pkg::*;
#(
  parameter logic [6:0] ADDR_BASE = 7'h44
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       scl,
  input  logic       sda,
  input  logic [1:0] strap,
  input  logic       quiet,
  input  logic [7:0] rdData,
  output logic       sdaLow,
  output regStrobe_t strb
);
  logic [2:0] sclSh, sdaSh;
  logic sclS, sclP, sdaS, sdaP, sclRise, sclFall, startDet, stopDet;
  busState_t state;
  logic [3:0] bitCnt;
  logic [7:0] shReg;
  logic isRead, hostAck, sdaLowR;
  logic [6:0] myAddr;

  assign myAddr   = ADDR_BASE + {5'd0, strap};
  assign sclS     = sclSh[1];
  assign sclP     = sclSh[2];
  assign sdaS     = sdaSh[1];
  assign sdaP     = sdaSh[2];
  assign sclRise  = sclS & ~sclP;
  assign sclFall  = ~sclS & sclP;
  assign startDet = sclS & sclP & ~sdaS & sdaP;
  assign stopDet  = sclS & sclP & sdaS & ~sdaP;
  assign sdaLow   = sdaLowR;

  always_comb begin
    strb.data     = shReg;
    strb.ptrLoad  = (state == S_PTR) && sclFall && (bitCnt == 4'd8);
    strb.wrStrobe = (state == S_WDAT) && sclFall && (bitCnt == 4'd8);
    strb.rdFetch  = sclFall && (((state == S_ADDR_ACK) && isRead) ||
                                ((state == S_RACK) && hostAck));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSh <= 3'b111; sdaSh <= 3'b111;
      state <= S_IDLE; bitCnt <= '0; shReg <= '0;
      isRead <= 1'b0; hostAck <= 1'b0; sdaLowR <= 1'b0;
    end else begin
      sclSh <= {sclSh[1:0], scl};
      sdaSh <= {sdaSh[1:0], sda};
      if (startDet) begin
        state <= S_ADDR; bitCnt <= '0; sdaLowR <= 1'b0;
      end else if (stopDet) begin
        state <= S_IDLE; sdaLowR <= 1'b0;
      end else begin
        case (state)
          S_ADDR, S_PTR, S_WDAT: begin
            if (sclRise && bitCnt < 4'd8) begin
              shReg  <= {shReg[6:0], sdaS};
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              if (state == S_ADDR) begin
                if (shReg[7:1] == myAddr && !quiet) begin
                  sdaLowR <= 1'b1; isRead <= shReg[0]; state <= S_ADDR_ACK;
                end else begin
                  state <= S_IDLE;
                end
              end else begin
                sdaLowR <= 1'b1;
                state   <= (state == S_PTR) ? S_PTR_ACK : S_WDAT_ACK;
              end
            end
          end
          S_ADDR_ACK: if (sclFall) begin
            bitCnt <= '0;
            if (isRead) begin
              shReg <= rdData; sdaLowR <= ~rdData[7]; state <= S_RDAT;
            end else begin
              sdaLowR <= 1'b0; state <= S_PTR;
            end
          end
          S_PTR_ACK, S_WDAT_ACK: if (sclFall) begin
            sdaLowR <= 1'b0; bitCnt <= '0; state <= S_WDAT;
          end
          S_RDAT: if (sclFall) begin
            if (bitCnt == 4'd7) begin
              sdaLowR <= 1'b0; state <= S_RACK;
            end else begin
              shReg   <= {shReg[6:0], 1'b0};
              sdaLowR <= ~shReg[6];
              bitCnt  <= bitCnt + 4'd1;
            end
          end
          S_RACK: begin
            if (sclRise) hostAck <= ~sdaS;
            else if (sclFall) begin
              if (hostAck) begin
                shReg <= rdData; sdaLowR <= ~rdData[7];
                bitCnt <= '0; state <= S_RDAT;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regmap_regs.sv
module i2c_regmap_regs
  import i2c_regmap_pkg::*;
#(
  parameter logic [7:0] CHIP_ID  = 8'h11,
  parameter int         WR_BASE  = 12,
  parameter int         RST_CLKS = 1600000
) (
  input  logic       clk,
  input  logic       rstN,
  input  regStrobe_t strb,
  input  logic [6:0] coreFlags,
  input  logic [7:0] sliderPos,
  input  logic [7:0] regRdData,
  output logic [7:0] rdData,
  output logic [7:0] regAddr,
  output logic       regWrEn,
  output logic [7:0] regWrData,
  output logic       quiet,
  output logic       changeN,
  output logic       softRst
);
  localparam int CW = $clog2(RST_CLKS + 1);
  localparam logic [7:0] ADR_ID = 8'd0, ADR_STAT = 8'd2, ADR_SLD = 8'd5, ADR_RST = 8'd11;

  logic [7:0] ptr, seenStat, seenSlider, genStatus;
  logic resetFlag, pend, softRstR;
  logic [CW-1:0] cnt;

  assign genStatus = {resetFlag, coreFlags};
  assign regAddr   = ptr;
  assign regWrData = strb.data;
  assign regWrEn   = strb.wrStrobe && !pend && (ptr >= 8'(WR_BASE));
  assign quiet     = pend;
  assign softRst   = softRstR;
  assign changeN   = pend || ((genStatus == seenStat) && (sliderPos == seenSlider));

  always_comb begin
    case (ptr)
      ADR_ID:   rdData = CHIP_ID;
      ADR_STAT: rdData = genStatus;
      ADR_SLD:  rdData = sliderPos;
      ADR_RST:  rdData = 8'h00;
      default:  rdData = regRdData;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0; resetFlag <= 1'b1; seenStat <= '0; seenSlider <= '0;
      pend <= 1'b0; cnt <= '0; softRstR <= 1'b0;
    end else begin
      softRstR <= 1'b0;
      if (pend) begin
        if (cnt == CW'(RST_CLKS - 1)) begin
          ptr <= '0; resetFlag <= 1'b1; seenStat <= '0; seenSlider <= '0;
          pend <= 1'b0; cnt <= '0; softRstR <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        if (strb.ptrLoad) ptr <= strb.data;
        if (strb.wrStrobe) begin
          if (ptr == ADR_RST && strb.data != 8'h00) begin
            pend <= 1'b1; cnt <= '0;
          end
          if (ptr != 8'hFF) ptr <= ptr + 8'd1;
        end
        if (strb.rdFetch) begin
          if (ptr == ADR_STAT) begin
            resetFlag <= 1'b0;
            seenStat  <= {1'b0, coreFlags};
          end
          if (ptr == ADR_SLD) seenSlider <= sliderPos;
          if (ptr != 8'hFF) ptr <= ptr + 8'd1;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_regmap_target.sv
module i2c_regmap_target
  import i2c_regmap_pkg::*;
#(
  parameter logic [6:0] ADDR_BASE = 7'h44,
  parameter logic [7:0] CHIP_ID   = 8'h11,
  parameter int         WR_BASE   = 12,
  parameter int         RST_CLKS  = 1600000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       scl,
  input  logic       sda,
  output logic       sdaLow,
  input  logic [1:0] strap,
  input  logic [6:0] coreFlags,
  input  logic [7:0] sliderPos,
  output logic [7:0] regAddr,
  output logic       regWrEn,
  output logic [7:0] regWrData,
  input  logic [7:0] regRdData,
  output logic       softRst,
  output logic       changeN
);
  regStrobe_t strb;
  logic quiet;
  logic [7:0] rdData;

  i2c_regmap_ctl #(.ADDR_BASE(ADDR_BASE)) u_ctl (
    .clk(clk), .rstN(rstN), .scl(scl), .sda(sda), .strap(strap),
    .quiet(quiet), .rdData(rdData), .sdaLow(sdaLow), .strb(strb)
  );

  i2c_regmap_regs #(.CHIP_ID(CHIP_ID), .WR_BASE(WR_BASE), .RST_CLKS(RST_CLKS)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .coreFlags(coreFlags),
    .sliderPos(sliderPos), .regRdData(regRdData), .rdData(rdData),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .quiet(quiet), .changeN(changeN), .softRst(softRst)
  );
endmodule

// File: rtl/i2c_regmap_checker.sv
module i2c_regmap_checker
  import i2c_regmap_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       scl,
  input logic       sdaLow,
  input logic       changeN,
  input logic       quiet,
  input logic       softRst,
  input logic [7:0] regAddr,
  input logic       regWrEn,
  input regStrobe_t strb
);
  // R2: target SDA drive moves only while the bus clock is low
  p_sda_scl_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaLow) || $fell(sdaLow)) |-> !scl);

  // R3: a written byte advances the pointer by one below the ceiling
  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStrobe && !quiet && regAddr != 8'hFF) |=> regAddr == 8'($past(regAddr) + 8'd1));

  // R5: the pointer holds at 255
  p_ptr_ceiling_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 8'hFF && (strb.wrStrobe || strb.rdFetch)) |=> regAddr == 8'hFF);

  // R9: register-file writes only at or above the writable base
  p_wr_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> regAddr >= 8'd12);

  // R10: attention line released while the reset is pending
  p_quiet_release_r10: assert property (@(posedge clk) disable iff (!rstN)
    quiet |-> changeN);

  // R10 / R8: completed reset leaves the attention line active
  p_reset_attention_r8: assert property (@(posedge clk) disable iff (!rstN)
    softRst |-> !changeN);
endmodule

bind i2c_regmap_target i2c_regmap_checker u_chk (
  .clk(clk), .rstN(rstN), .scl(scl), .sdaLow(sdaLow), .changeN(changeN),
  .quiet(quiet), .softRst(softRst), .regAddr(regAddr), .regWrEn(regWrEn),
  .strb(strb)
);

// File: tb/i2c_regmap_target_test.sv
`timescale 1ns/1ps
module i2c_regmap_target_test;
  localparam int  RSTC = 2000;
  localparam time Q    = 200ns;
  localparam logic [6:0] BASE = 7'h44;

  logic clk = 1'b0, rstN = 1'b0;
  logic mScl = 1'b1, mSdaLow = 1'b0;
  logic sdaLow, sdaBus, regWrEn, softRst, changeN;
  logic [1:0] strap = 2'd0;
  logic [6:0] coreFlags = 7'h00;
  logic [7:0] sliderPos = 8'h00, regAddr, regWrData, regRdData;
  logic [7:0] memv [256];
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];
  int checks = 0, fails = 0, wrCount = 0, srCount = 0, ackCnt = 0;
  logic lastAck;
  bit done = 0;

  always #5 clk = ~clk;
  assign sdaBus    = ~(mSdaLow | sdaLow);
  assign regRdData = regAddr ^ 8'h5A;

  i2c_regmap_target #(.RST_CLKS(RSTC)) uut (
    .clk(clk), .rstN(rstN), .scl(mScl), .sda(sdaBus), .sdaLow(sdaLow),
    .strap(strap), .coreFlags(coreFlags), .sliderPos(sliderPos),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .softRst(softRst), .changeN(changeN)
  );

  always @(posedge clk) begin
    if (regWrEn) begin memv[regAddr] <= regWrData; wrCount <= wrCount + 1; end
    if (softRst) srCount <= srCount + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bitOut(input logic b);
    mSdaLow = ~b; #(Q/2); mScl = 1'b1; #Q; mScl = 1'b0; #(Q/2);
  endtask
  task automatic bitIn(output logic b);
    mSdaLow = 1'b0; #(Q/2); mScl = 1'b1; #(Q/2); b = sdaBus; #(Q/2); mScl = 1'b0; #(Q/2);
  endtask
  task automatic busStart();
    mSdaLow = 1'b0; mScl = 1'b1; #(Q/2); mSdaLow = 1'b1; #(Q/2); mScl = 1'b0; #(Q/2);
  endtask
  task automatic busStop();
    mSdaLow = 1'b1; #(Q/2); mScl = 1'b1; #(Q/2); mSdaLow = 1'b0; #Q;
  endtask
  task automatic sendByte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bitOut(d[i]);
    bitIn(a); ack = ~a;
  endtask
  task automatic recvByte(input logic ackIt, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin bitIn(b); d[i] = b; end
    bitOut(~ackIt);
    mSdaLow = 1'b0;
  endtask

  // write pointer p then n bytes from wbuf; ackCnt counts all acks
  task automatic writeTo(input logic [6:0] a, input logic [7:0] p, input int n);
    logic ak;
    ackCnt = 0;
    busStart();
    sendByte({a, 1'b0}, ak); lastAck = ak; ackCnt += int'(ak);
    if (ak) begin
      sendByte(p, ak); ackCnt += int'(ak);
      for (int i = 0; i < n; i++) begin sendByte(wbuf[i], ak); ackCnt += int'(ak); end
    end
    busStop();
  endtask

  // optionally set pointer, then read n bytes into rbuf
  task automatic readFrom(input logic setp, input logic [7:0] p, input int n);
    logic ak;
    if (setp) writeTo(BASE + 7'(strap), p, 0);
    busStart();
    sendByte({BASE + 7'(strap), 1'b1}, ak); lastAck = ak;
    if (ak) for (int i = 0; i < n; i++) recvByte(i < n - 1, rbuf[i]);
    busStop();
  endtask

  task automatic tReset();
    chk("R8 changeN active after reset", changeN, 1'b0);
    chk("R2 sda released after reset", sdaLow, 1'b0);
  endtask

  task automatic tIdRead();
    readFrom(1, 8'd0, 1);
    chk("R6 identity byte", rbuf[0], 8'h11);
    chk("R4 released after nack and stop", sdaLow, 1'b0);
  endtask

  task automatic tStatus();
    coreFlags = 7'h40;
    readFrom(1, 8'd2, 1);
    chk("R7 status with reset flag and overrun", rbuf[0], 8'hC0);
    chk("R8 changeN high after status read", changeN, 1'b1);
    readFrom(1, 8'd2, 1);
    chk("R7 reset flag cleared by read", rbuf[0], 8'h40);
  endtask

  task automatic tChange();
    sliderPos = 8'h37; #(Q);
    chk("R8 slider change pulls changeN", changeN, 1'b0);
    readFrom(1, 8'd5, 1);
    chk("R8 slider byte value", rbuf[0], 8'h37);
    chk("R8 changeN back high after slider read", changeN, 1'b1);
    coreFlags = 7'h00; #(Q);
    chk("R8 status change pulls changeN", changeN, 1'b0);
    readFrom(1, 8'd2, 1);
    chk("R7 status after flag drop", rbuf[0], 8'h00);
    chk("R8 changeN high after status read", changeN, 1'b1);
  endtask

  task automatic tAddrMatch();
    writeTo(BASE + 7'd1, 8'd20, 0);
    chk("R1 foreign address not acked", lastAck, 1'b0);
    strap = 2'd2;
    writeTo(BASE + 7'd2, 8'd20, 0);
    chk("R1 strapped address acked", lastAck, 1'b1);
    writeTo(BASE, 8'd20, 0);
    chk("R1 base address refused under strap 2", lastAck, 1'b0);
    strap = 2'd0;
  endtask

  task automatic tBurstWrite();
    int w0;
    w0 = wrCount;
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
    writeTo(BASE, 8'd20, 3);
    chk("R3 all bytes acked", ackCnt, 5);
    chk("R3 byte at 20", memv[20], 8'hA1);
    chk("R3 byte at 21", memv[21], 8'hB2);
    chk("R3 byte at 22", memv[22], 8'hC3);
    chk("R9 three port writes", wrCount - w0, 3);
  endtask

  task automatic tBurstRead();
    readFrom(1, 8'd40, 4);
    for (int i = 0; i < 4; i++)
      chk("R4 burst read byte", rbuf[i], 8'(40 + i) ^ 8'h5A);
  endtask

  task automatic tSaturate();
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    writeTo(BASE, 8'd254, 3);
    chk("R5 write at 254", memv[254], 8'h11);
    chk("R5 last write lands on 255", memv[255], 8'h33);
    readFrom(1, 8'd255, 2);
    chk("R5 read at 255", rbuf[0], 8'hA5);
    chk("R5 read repeats 255", rbuf[1], 8'hA5);
  endtask

  task automatic tReadOnly();
    int w0, s0;
    w0 = wrCount; s0 = srCount;
    wbuf[0] = 8'h55;
    writeTo(BASE, 8'd0, 1);
    chk("R9 write to identity acked", ackCnt, 3);
    readFrom(1, 8'd0, 1);
    chk("R9 identity unchanged", rbuf[0], 8'h11);
    writeTo(BASE, 8'd3, 1);
    chk("R9 no port write below base", wrCount - w0, 0);
    readFrom(1, 8'd11, 1);
    chk("R9 reset location reads zero", rbuf[0], 8'h00);
    wbuf[0] = 8'h00;
    writeTo(BASE, 8'd11, 1);
    writeTo(BASE, 8'd20, 0);
    chk("R10 zero write keeps target responsive", lastAck, 1'b1);
    chk("R10 zero write no reset pulse", srCount - s0, 0);
  endtask

  task automatic tResetCmd();
    sliderPos = 8'h99; #(Q);
    chk("R8 changeN low before reset command", changeN, 1'b0);
    wbuf[0] = 8'h01;
    writeTo(BASE, 8'd11, 1);
    chk("R10 changeN released while pending", changeN, 1'b1);
    writeTo(BASE, 8'd0, 0);
    chk("R10 address refused while pending", lastAck, 1'b0);
    repeat (RSTC + 20) @(negedge clk);
    chk("R10 one softRst pulse", srCount, 1);
    chk("R10 changeN active after reset", changeN, 1'b0);
    busStart();
    begin
      logic ak;
      sendByte({BASE, 1'b1}, ak);
      chk("R10 address acked after reset", ak, 1'b1);
      recvByte(1'b0, rbuf[0]);
    end
    busStop();
    chk("R10 pointer back at 0", rbuf[0], 8'h11);
    readFrom(1, 8'd2, 1);
    chk("R10 reset flag set again", rbuf[0], 8'h80);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1_500_000ns;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 256; i++) memv[i] = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    tReset();
    tIdRead();
    tStatus();
    tChange();
    tAddrMatch();
    tBurstWrite();
    tBurstRead();
    tSaturate();
    tReadOnly();
    tResetCmd();
    finishRun();
  end
endmodule